// File: doc/BRIEF.md
# Half-word multiply-add unit

This execution unit takes three 32-bit operand words A, B and C. It multiplies one 16-bit half of A by one 16-bit half of B and can shift that product up by a half word. It then adds a version of C that a two-bit mode field has shaped. As a last step it can replace the upper half of the sum with the lower half of B. Chained, this lets a wide multiply be built from half-word pieces. All arithmetic is unsigned and wraps modulo 2^32.

A two-bit source-form input tells the unit how the operands were fetched upstream. Two of the forms change its behaviour. In the immediate form, B is a 16-bit value, so the upper 16 bits of the B port are replaced by zeros. In the register-B / constant-C form, merging is never applied. One input strobe gives one registered result on the next clock edge.

Top module: `hmad_unit`

## Requirements
- R1: The A factor is a_in[31:16] when sel_a_hi is 1 and a_in[15:0] otherwise, zero-extended.
- R2: The B factor is bits [31:16] of the effective B when sel_b_hi is 1 and bits [15:0] otherwise, zero-extended.
- R3: The product is the unsigned 32-bit product of the two factors. When prod_shl is 1 it is shifted left by 16 and any bits above bit 31 are dropped, so the low 16 bits of the product become zero.
- R4: c_mode selects the addend. 0 gives c_in unchanged. 1 gives c_in[15:0] zero-extended. 2 gives c_in[31:16] zero-extended. 3 gives c_in plus (effective B << 16) modulo 2^32.
- R5: The sum is the possibly shifted product plus the addend, modulo 2^32.
- R6: When merging applies, result[15:0] is sum[15:0] and result[31:16] is effective B[15:0]. This holds whatever sel_b_hi is.
- R7: With src_form 3 (immediate B), effective B is {16'h0, b_in[15:0]} and b_in[31:16] has no effect. With src_form 0 (register B, register C) and src_form 1 (constant B, register C), effective B is b_in.
- R8: With src_form 2 (register B, constant C), merging never applies, whatever merge_en is. In the other forms, merging applies when merge_en is 1.
- R9: A result computed from inputs presented with in_valid=1 appears on result with out_valid=1 after the next rising clock edge. After an edge with in_valid=0, out_valid is 0 and result keeps its value.
- R10: A synchronous active-high rst drives out_valid to 0 and result to 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| a_in | input | 32 | Operand A |
| b_in | input | 32 | Operand B |
| c_in | input | 32 | Operand C |
| sel_a_hi | input | 1 | Take the upper half of A as factor |
| sel_b_hi | input | 1 | Take the upper half of B as factor |
| prod_shl | input | 1 | Shift the product left by 16 |
| c_mode | input | 2 | Addend conditioning mode |
| merge_en | input | 1 | Put B[15:0] into the upper result half |
| src_form | input | 2 | Operand source form (0 RR, 1 const-B, 2 const-C, 3 immediate B) |
| out_valid | output | 1 | Result is valid |
| result | output | 32 | Registered result |

## Verification
The main sweep crosses eight operand triples with all 64 combinations of half selects, shift, addend mode and merge. The source form rotates across the sweep, and each result is compared with a reference model. The triples include all-zero, all-ones, 0xFFFF halves and mixed patterns. The all-ones and 0xFFFF values force carries out of bit 31 in the product shift, in the mode-3 addend and in the final sum. Mixed patterns that differ between their halves show whether the wrong half was picked. Directed cases separate the immediate form from the register form by putting non-zero bits in b_in[31:16]. They also show that merge is ignored in the constant-C form, and that merge takes B's low half even when the high B half feeds the multiplier. Further cases cover the hold and idle behaviour and reset during a pending strobe.

// File: rtl/hmad_pkg.sv
package hmad_pkg;

    typedef enum logic [1:0] {
        CM_PASS  = 2'd0,
        CM_LOW   = 2'd1,
        CM_HIGH  = 2'd2,
        CM_ADD_B = 2'd3
    } cmode_e;

    typedef enum logic [1:0] {
        SF_REG_REG   = 2'd0,
        SF_CONST_B   = 2'd1,
        SF_CONST_C   = 2'd2,
        SF_IMM_B     = 2'd3
    } src_form_e;

    typedef struct packed {
        logic      a_hi;
        logic      b_hi;
        logic      shl;
        cmode_e    cmode;
        logic      merge;
        src_form_e form;
    } hmad_ctrl_t;

    // merging is suppressed for the register-B / constant-C form
    function automatic logic merge_allowed(input src_form_e f);
        return f != SF_CONST_C;
    endfunction

    function automatic logic imm_b_form(input src_form_e f);
        return f == SF_IMM_B;
    endfunction

endpackage

// File: rtl/hmad_opsel.sv
module hmad_opsel
    import hmad_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]   a_word,
    input  logic [DATA_W-1:0]   b_word,
    input  hmad_ctrl_t          ctl,
    output logic [DATA_W/2-1:0] a_half,
    output logic [DATA_W/2-1:0] b_half,
    output logic [DATA_W-1:0]   b_eff
);
    localparam int HALF_W = DATA_W / 2;

    // effective B: immediate form keeps only the low half
    always_comb begin
        if (imm_b_form(ctl.form))
            b_eff = {{HALF_W{1'b0}}, b_word[HALF_W-1:0]};
        else
            b_eff = b_word;
    end

    always_comb begin
        a_half = ctl.a_hi ? a_word[DATA_W-1:HALF_W] : a_word[HALF_W-1:0];
        b_half = ctl.b_hi ? b_eff[DATA_W-1:HALF_W]  : b_eff[HALF_W-1:0];
    end

endmodule

// File: rtl/hmad_cond_c.sv
module hmad_cond_c
    import hmad_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] c_word,
    input  logic [DATA_W-1:0] b_eff,
    input  cmode_e            mode,
    output logic [DATA_W-1:0] c_cond
);
    localparam int HALF_W = DATA_W / 2;

    always_comb begin
        unique case (mode)
            CM_PASS:  c_cond = c_word;
            CM_LOW:   c_cond = {{HALF_W{1'b0}}, c_word[HALF_W-1:0]};
            CM_HIGH:  c_cond = {{HALF_W{1'b0}}, c_word[DATA_W-1:HALF_W]};
            CM_ADD_B: c_cond = c_word + (b_eff << HALF_W);
            default:  c_cond = c_word;
        endcase
    end

endmodule

// File: rtl/hmad_accum.sv
module hmad_accum #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W/2-1:0] a_half,
    input  logic [DATA_W/2-1:0] b_half,
    input  logic                shl,
    input  logic [DATA_W-1:0]   c_cond,
    input  logic                merge_eff,
    input  logic [DATA_W-1:0]   b_eff,
    output logic [DATA_W-1:0]   res_d
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] prod_raw;
    logic [DATA_W-1:0] prod_adj;
    logic [DATA_W-1:0] sum;

    always_comb begin
        prod_raw = DATA_W'(a_half) * DATA_W'(b_half);
        prod_adj = shl ? (prod_raw << HALF_W) : prod_raw;
        sum      = prod_adj + c_cond;
        if (merge_eff)
            res_d = {b_eff[HALF_W-1:0], sum[HALF_W-1:0]};
        else
            res_d = sum;
    end

endmodule

// File: rtl/hmad_unit.sv
module hmad_unit
    import hmad_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic [DATA_W-1:0] c_in,
    input  logic              sel_a_hi,
    input  logic              sel_b_hi,
    input  logic              prod_shl,
    input  logic [1:0]        c_mode,
    input  logic              merge_en,
    input  logic [1:0]        src_form,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    localparam int HALF_W = DATA_W / 2;

    hmad_ctrl_t          ctl;
    logic [HALF_W-1:0]   a_half;
    logic [HALF_W-1:0]   b_half;
    logic [DATA_W-1:0]   b_eff;
    logic [DATA_W-1:0]   c_cond;
    logic [DATA_W-1:0]   res_d;
    logic                merge_eff;

    always_comb begin
        ctl.a_hi  = sel_a_hi;
        ctl.b_hi  = sel_b_hi;
        ctl.shl   = prod_shl;
        ctl.cmode = cmode_e'(c_mode);
        ctl.merge = merge_en;
        ctl.form  = src_form_e'(src_form);
        merge_eff = ctl.merge && merge_allowed(ctl.form);
    end

    hmad_opsel #(.DATA_W(DATA_W)) u_opsel (
        .a_word (a_in),
        .b_word (b_in),
        .ctl    (ctl),
        .a_half (a_half),
        .b_half (b_half),
        .b_eff  (b_eff)
    );

    hmad_cond_c #(.DATA_W(DATA_W)) u_cond (
        .c_word (c_in),
        .b_eff  (b_eff),
        .mode   (ctl.cmode),
        .c_cond (c_cond)
    );

    hmad_accum #(.DATA_W(DATA_W)) u_accum (
        .a_half    (a_half),
        .b_half    (b_half),
        .shl       (ctl.shl),
        .c_cond    (c_cond),
        .merge_eff (merge_eff),
        .b_eff     (b_eff),
        .res_d     (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                result <= res_d;
        end
    end

    // R9: strobe gives a valid result one edge later
    a_r9_valid_next: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R9: no strobe, no valid
    a_r9_idle_next: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R9: result holds without a strobe
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    // R10: reset clears the valid flag and result
    a_r10_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0));

    // R6, R8: merging places B low half on top
    a_r6_merge_high: assert property (@(posedge clk) disable iff (rst)
        (in_valid && merge_en && src_form != 2'd2)
        |=> result[DATA_W-1:HALF_W] == $past(b_in[HALF_W-1:0]));

    // R3: shifted product leaves the low half to the addend
    a_r3_shift_low: assert property (@(posedge clk) disable iff (rst)
        (in_valid && prod_shl && c_mode == 2'd1)
        |=> result[HALF_W-1:0] == $past(c_in[HALF_W-1:0]));

endmodule

// File: tb/sim_hmad_unit.sv
module sim_hmad_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] a_in, b_in, c_in;
    logic        sel_a_hi, sel_b_hi, prod_shl, merge_en;
    logic [1:0]  c_mode, src_form;
    logic        out_valid;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    hmad_unit #(.DATA_W(32)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .a_in(a_in), .b_in(b_in), .c_in(c_in),
        .sel_a_hi(sel_a_hi), .sel_b_hi(sel_b_hi), .prod_shl(prod_shl),
        .c_mode(c_mode), .merge_en(merge_en), .src_form(src_form),
        .out_valid(out_valid), .result(result)
    );

    // operand triples {a, b, c}
    localparam logic [95:0] VEC [8] = '{
        {32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {32'h0000_FFFF, 32'hFFFF_0000, 32'h0000_0001},
        {32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_0F0F},
        {32'hFFFF_0001, 32'h0001_FFFF, 32'h8000_0000},
        {32'h0001_0002, 32'h0003_0004, 32'hFFFF_FFFF},
        {32'hDEAD_BEEF, 32'hCAFE_F00D, 32'h1357_9BDF},
        {32'h0000_FFFF, 32'h0000_FFFF, 32'hFFFF_0000}
    };

    function automatic logic [31:0] ref_calc(
        input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
        input logic ahi, input logic bhi, input logic shl,
        input logic [1:0] mode, input logic mg, input logic [1:0] form);
        logic [31:0] beff, fa, fb, p, cc, s;
        beff = (form == 2'd3) ? (b & 32'h0000_FFFF) : b;
        fa   = ahi ? (a >> 16) : (a & 32'h0000_FFFF);
        fb   = ahi === 1'bx ? 32'h0 : (bhi ? (beff >> 16) : (beff & 32'h0000_FFFF));
        p    = fa * fb;
        if (shl) p = p << 16;
        case (mode)
            2'd0: cc = c;
            2'd1: cc = c & 32'h0000_FFFF;
            2'd2: cc = c >> 16;
            default: cc = c + (beff << 16);
        endcase
        s = p + cc;
        if (mg && form != 2'd2) s = {beff[15:0], s[15:0]};
        return s;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                         input logic ahi, input logic bhi, input logic shl,
                         input logic [1:0] mode, input logic mg, input logic [1:0] form);
        @(negedge clk);
        in_valid = 1'b1;
        a_in = a; b_in = b; c_in = c;
        sel_a_hi = ahi; sel_b_hi = bhi; prod_shl = shl;
        c_mode = mode; merge_en = mg; src_form = form;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_one(input string req, input logic [31:0] a, input logic [31:0] b,
                           input logic [31:0] c, input logic ahi, input logic bhi,
                           input logic shl, input logic [1:0] mode, input logic mg,
                           input logic [1:0] form, input logic [31:0] exp);
        drive(a, b, c, ahi, bhi, shl, mode, mg, form);
        chk({req, " valid"}, {31'h0, out_valid}, 32'h1);
        chk(req, result, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        rst = 1'b1; in_valid = 1'b0;
        a_in = '0; b_in = '0; c_in = '0;
        sel_a_hi = 0; sel_b_hi = 0; prod_shl = 0; c_mode = 0; merge_en = 0; src_form = 0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 reset valid", {31'h0, out_valid}, 32'h0);
        chk("R10 reset result", result, 32'h0);
        rst = 1'b0;

        // table sweep: R1 R2 R3 R4 R5 R6 R7 R8
        for (int v = 0; v < 8; v++) begin
            for (int k = 0; k < 64; k++) begin
                logic [31:0] a, b, c;
                logic [1:0] f;
                a = VEC[v][95:64]; b = VEC[v][63:32]; c = VEC[v][31:0];
                f = 2'((v + k) % 4);
                run_one("R1-sweep R5", a, b, c, k[0], k[1], k[2], k[4:3], k[5], f,
                        ref_calc(a, b, c, k[0], k[1], k[2], k[4:3], k[5], f));
            end
        end

        // R5: wrap of the sum
        run_one("R5 wrap", 32'h0000_FFFF, 32'h0000_FFFF, 32'hFFFF_FFFF,
                0, 0, 0, 2'd0, 0, 2'd0, 32'hFFFE_0000);
        // R3: shifted product drops upper bits
        run_one("R3 shift", 32'h0000_FFFF, 32'h0000_FFFF, 32'h0,
                0, 0, 1, 2'd0, 0, 2'd0, 32'h0001_0000);
        // R1: upper A half
        run_one("R1 a_hi", 32'h0003_7777, 32'h0000_0005, 32'h0,
                1, 0, 0, 2'd0, 0, 2'd0, 32'h0000_000F);
        // R2: upper B half
        run_one("R2 b_hi", 32'h0000_0002, 32'h0009_1111, 32'h0,
                0, 1, 0, 2'd0, 0, 2'd0, 32'h0000_0012);
        // R4: mode 2 upper C half, mode 3 adds B << 16
        run_one("R4 mode2", 32'h0, 32'h0, 32'hABCD_1234,
                0, 0, 0, 2'd2, 0, 2'd0, 32'h0000_ABCD);
        run_one("R4 mode3", 32'h0, 32'h0001_0002, 32'h0000_0010,
                0, 0, 0, 2'd3, 0, 2'd0, 32'h0002_0010);
        // R7: immediate form ignores b_in[31:16]
        run_one("R7 imm", 32'h0000_0002, 32'hABCD_0003, 32'h0000_0005,
                0, 1, 0, 2'd0, 0, 2'd3, 32'h0000_0005);
        run_one("R7 reg", 32'h0000_0002, 32'hABCD_0003, 32'h0000_0005,
                0, 1, 0, 2'd0, 0, 2'd0, 32'h0001_579F);
        // R8: merge ignored in constant-C form, applied in constant-B form
        run_one("R8 no merge", 32'h0000_0001, 32'h0007_0009, 32'h0,
                0, 0, 0, 2'd0, 1, 2'd2, 32'h0000_0009);
        run_one("R8 merge", 32'h0000_0001, 32'h0007_0009, 32'h0,
                0, 0, 0, 2'd0, 1, 2'd1, 32'h0009_0009);
        // R6: merge uses B low half even when B high half is the factor
        run_one("R6 merge bhi", 32'h0000_0001, 32'h1234_5678, 32'h0,
                0, 1, 0, 2'd0, 1, 2'd0, 32'h5678_1234);

        // R9: idle cycle with changed inputs keeps result, drops valid
        held = result;
        @(negedge clk);
        a_in = 32'hFFFF_FFFF; b_in = 32'h1111_1111; c_in = 32'h2222_2222;
        @(negedge clk);
        chk("R9 idle valid", {31'h0, out_valid}, 32'h0);
        chk("R9 hold", result, held);

        // R10: reset wins over a pending strobe
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        chk("R10 reset strobe valid", {31'h0, out_valid}, 32'h0);
        chk("R10 reset strobe result", result, 32'h0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule